// File: doc/BRIEF.md
# Round-Robin I2C Multi-Target Writer

This block is an I2C bus master that runs without any command input. After reset it waits through an idle gap. It then writes a single data byte to one 7-bit target. It moves to the next entry of a fixed four-entry table and repeats this forever. After the last entry it wraps back to the first. Each entry pairs a target address with its own data byte. The addresses are 0x0A, 0x0B, 0x0C and 0x0D, and the data bytes are 0xA1, 0xB1, 0xC1 and 0xD1.

The bus lines are open-drain. The block only asserts active-high pull-low enables for SCL and SDA, and it reads the resolved SDA level back. The bit rate comes from the system clock through a programmable divider. A target that does not acknowledge, either on the address byte or on the data byte, gets a repeated START. The same transfer is then re-sent to it, and the rotation does not move on.

Status outputs show the following:
- a busy level while a transfer is on the bus,
- a one-cycle pulse when a transfer completes,
- a one-cycle pulse for every NACK,
- the current table index.

Top module: `i2c_rr_writer`

## Requirements
- R1: Entry k (k = 0..3) uses target address 0x0A+k and data byte 0xA1+0x10*k. The address byte is the 7-bit address followed by a 0 write bit, and every byte goes out MSB first.
- R2: `idx_o` shows the table entry of the transfer in progress. It changes only together with `done_o`, by one step, and it wraps from 3 back to 0.
- R3: A transfer is START, the address byte, exactly one data byte and STOP. SDA changes while SCL is high only to form START (SDA falling) or STOP (SDA rising).
- R4: While a transfer runs, consecutive SCL rising edges are exactly `div_i` clock cycles apart (for `div_i` a multiple of 4 and at least 8; 24 is the intended setting).
- R5: On the ninth clock of each byte SDA is released and sampled. A high level is a NACK. It gives a one-cycle `nack_o` pulse and a repeated START to the same entry, and `idx_o` does not change.
- R6: A new START comes only after the previous STOP has completed and at least `IDLE_CYC` cycles have passed. Both lines stay released during this gap.
- R7: `busy_o` is high from START through STOP. `done_o` pulses for one cycle after each STOP, with `busy_o` already low.
- R8: During reset both pull-low enables, `busy_o`, `done_o` and `nack_o` are 0, and `idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_i | input | 16 | SCL period in system clock cycles |
| sda_i | input | 1 | Resolved SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Transfer on the bus |
| done_o | output | 1 | One-cycle pulse per completed transfer |
| nack_o | output | 1 | One-cycle pulse per NACK |
| idx_o | output | 2 | Current table entry |

## Verification
The hardest case to reach is a NACK on the data byte after the address byte of the same transfer was acknowledged. That NACK must cause a repeated START with the address byte sent again, not a STOP or a skip to the next entry. The bench models the target and decides each acknowledge from the transfer count. It refuses the address byte on the first attempt at entry 1 and the data byte on the first attempt at entry 2. It then checks the retried bytes, the NACK pulse count and the unchanged index. The run continues past the wrap back to entry 0.

// File: rtl/i2c_rr_pkg.sv
package i2c_rr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_RESTART,
    ST_STOP
  } seq_st_e;
endpackage

// File: rtl/i2c_rr_qtick.sv
// Quarter-bit tick: one SCL period is four ticks of div_i/4 cycles.
module i2c_rr_qtick #(
  parameter int DIV_W = 16,
  localparam int QW = DIV_W - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [QW-1:0] qlen, cnt_q;

  assign qlen   = (div_i[DIV_W-1:2] == '0) ? QW'(1) : div_i[DIV_W-1:2];
  assign tick_o = run_i && (cnt_q >= qlen - QW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + QW'(1);
  end

  // R4
  tick_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/i2c_rr_table.sv
// Address/data pairs computed per entry.
module i2c_rr_table #(
  parameter int         N_TGT     = 4,
  parameter logic [6:0] BASE_ADDR = 7'h0A,
  parameter logic [7:0] BASE_DATA = 8'hA1,
  parameter logic [7:0] DATA_STEP = 8'h10,
  localparam int IW = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic [IW-1:0] idx_i,
  output logic [6:0]    addr_o,
  output logic [7:0]    data_o
);
  logic [6:0] addr_tab [N_TGT];
  logic [7:0] data_tab [N_TGT];

  for (genvar g = 0; g < N_TGT; g++) begin : g_ent
    assign addr_tab[g] = BASE_ADDR + 7'(g);
    assign data_tab[g] = BASE_DATA + 8'(8'(g) * DATA_STEP);
  end

  assign addr_o = addr_tab[idx_i];
  assign data_o = data_tab[idx_i];
endmodule

// File: rtl/i2c_rr_seq.sv
module i2c_rr_seq
  import i2c_rr_pkg::*;
#(
  parameter int N_TGT    = 4,
  parameter int IDLE_CYC = 1000,
  localparam int IW = (N_TGT > 1) ? $clog2(N_TGT) : 1,
  localparam int GW = $clog2(IDLE_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          sda_i,
  input  logic [6:0]    tgt_addr_i,
  input  logic [7:0]    tgt_data_i,
  output logic          run_o,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          nack_o,
  output logic [IW-1:0] idx_o
);
  seq_st_e       st_q;
  logic [1:0]    ph_q;
  logic [3:0]    bit_q;
  logic [7:0]    sh_q;
  logic          hold_q;
  logic [1:0]    bcnt_q;
  logic [GW-1:0] gap_q;
  logic [IW-1:0] idx_q;
  logic          done_q, nack_q;
  logic          scl_lo, sda_lo, bit_lo;

  assign bit_lo = (bit_q == 4'd8) ? 1'b0 : ~sh_q[7];

  // Phases: 0,1 SCL low; 2,3 SCL high. Data changes in phase 1.
  always_comb begin
    scl_lo = 1'b0;
    sda_lo = 1'b0;
    unique case (st_q)
      ST_START: begin
        scl_lo = (ph_q == 2'd3);
        sda_lo = (ph_q != 2'd0);
      end
      ST_BIT: begin
        scl_lo = (ph_q < 2'd2);
        sda_lo = (ph_q == 2'd0) ? hold_q : bit_lo;
      end
      ST_RESTART: scl_lo = (ph_q < 2'd2);
      ST_STOP: begin
        scl_lo = (ph_q < 2'd2);
        sda_lo = (ph_q == 2'd1) || (ph_q == 2'd2);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      hold_q <= 1'b0;
      bcnt_q <= '0;
      gap_q  <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      nack_q <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (gap_q == GW'(IDLE_CYC - 1)) begin
          st_q  <= ST_START;
          ph_q  <= '0;
          gap_q <= '0;
        end else begin
          gap_q <= gap_q + GW'(1);
        end
      end else if (tick_i) begin
        ph_q <= ph_q + 2'd1;
        if (ph_q == 2'd3) begin
          unique case (st_q)
            ST_START: begin
              st_q   <= ST_BIT;
              bit_q  <= '0;
              sh_q   <= {tgt_addr_i, 1'b0};
              hold_q <= 1'b1;
              bcnt_q <= 2'd1;
            end
            ST_BIT: begin
              if (bit_q != 4'd8) begin
                sh_q   <= {sh_q[6:0], 1'b0};
                hold_q <= sda_lo;
                bit_q  <= bit_q + 4'd1;
              end else if (sda_i) begin
                nack_q <= 1'b1;
                st_q   <= ST_RESTART;
              end else if (bcnt_q != '0) begin
                sh_q   <= tgt_data_i;
                bcnt_q <= bcnt_q - 2'd1;
                bit_q  <= '0;
                hold_q <= 1'b0;
              end else begin
                st_q <= ST_STOP;
              end
            end
            ST_RESTART: st_q <= ST_START;
            ST_STOP: begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              idx_q  <= (idx_q == IW'(N_TGT - 1)) ? '0 : idx_q + IW'(1);
            end
            default: st_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign run_o    = (st_q != ST_IDLE);
  assign busy_o   = (st_q != ST_IDLE);
  assign scl_oe_o = scl_lo;
  assign sda_oe_o = sda_lo;
  assign done_o   = done_q;
  assign nack_o   = nack_q;
  assign idx_o    = idx_q;

  // R3
  sda_hi_chg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_lo && !$past(scl_lo) && (sda_lo != $past(sda_lo)))
      |-> ($past(st_q) == ST_START || $past(st_q) == ST_STOP));
  // R3
  one_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_STOP) |-> (bcnt_q == '0));
  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R5
  nack_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && nack_o));
  // R2
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q != $past(idx_q)) |-> done_o);
endmodule

// File: rtl/i2c_rr_writer.sv
module i2c_rr_writer #(
  parameter int         N_TGT     = 4,
  parameter int         DIV_W     = 16,
  parameter int         IDLE_CYC  = 1000,
  parameter logic [6:0] BASE_ADDR = 7'h0A,
  parameter logic [7:0] BASE_DATA = 8'hA1,
  parameter logic [7:0] DATA_STEP = 8'h10,
  localparam int IW = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             nack_o,
  output logic [IW-1:0]    idx_o
);
  logic       run, tick;
  logic [6:0] tgt_addr;
  logic [7:0] tgt_data;

  i2c_rr_table #(
    .N_TGT(N_TGT), .BASE_ADDR(BASE_ADDR), .BASE_DATA(BASE_DATA), .DATA_STEP(DATA_STEP)
  ) u_table (
    .idx_i(idx_o), .addr_o(tgt_addr), .data_o(tgt_data)
  );

  i2c_rr_qtick #(.DIV_W(DIV_W)) u_qtick (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .div_i(div_i), .tick_o(tick)
  );

  i2c_rr_seq #(.N_TGT(N_TGT), .IDLE_CYC(IDLE_CYC)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .sda_i(sda_i),
    .tgt_addr_i(tgt_addr), .tgt_data_i(tgt_data), .run_o(run),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .busy_o(busy_o),
    .done_o(done_o), .nack_o(nack_o), .idx_o(idx_o)
  );
endmodule

// File: tb/i2c_rr_writer_bench.sv
module i2c_rr_writer_bench;
  localparam int IDLE = 1000;
  localparam int DIV  = 24;
  localparam int NTX  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] div = 16'(DIV);
  logic scl_oe, sda_oe, busy, done, nack;
  logic [1:0] idx;
  logic tb_sda_lo = 1'b0;
  wire  scl_ln = ~scl_oe;
  wire  sda_ln = ~(sda_oe | tb_sda_lo);

  i2c_rr_writer #(.IDLE_CYC(IDLE)) u_i2c_rr_writer (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .sda_i(sda_ln),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy),
    .done_o(done), .nack_o(nack), .idx_o(idx)
  );

  int total = 0, bad = 0;
  int t = 0, cyc = 0, stops = 0, last_stop = 0, last_rise = -1;
  int bitcnt = 0, byte_no = 0, sr = 0;
  int nack_exp = 0, nack_seen = 0;
  bit in_frame = 0, nack_pend = 0, nak_a = 0, nak_d = 0;
  bit prev_scl = 1, prev_sda = 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_addr(input int n);
    return 'h0A + (n % 4);
  endfunction
  function automatic int exp_data(input int n);
    return 'hA1 + 'h10 * (n % 4);
  endfunction

  // Target model and protocol monitor, evaluated every clock
  always @(negedge clk) begin
    if (rst_n) begin
      int e;
      bit nak;
      cyc++;
      if (nack) nack_seen++;
      if (done) begin
        chk(stops == t + 1, "R7 done after stop", stops, t + 1);
        chk(!busy, "R7 busy low at done", busy, 0);
        chk(idx == (t + 1) % 4, "R2 idx advance/wrap", idx, (t + 1) % 4);
        chk(scl_ln && sda_ln, "R6 bus released in gap", {scl_ln, sda_ln}, 3);
        t++;
      end
      if (prev_scl && scl_ln && prev_sda && !sda_ln) begin
        chk(!in_frame || nack_pend, "R3 no START inside transfer", in_frame, 0);
        chk(nack_seen == nack_exp, "R5 nack pulse count", nack_seen, nack_exp);
        chk(idx == t % 4, "R2 idx at START", idx, t % 4);
        chk(busy, "R7 busy during transfer", busy, 1);
        if (!nack_pend && stops > 0)
          chk(cyc - last_stop >= IDLE, "R6 idle gap", cyc - last_stop, IDLE);
        in_frame = 1; bitcnt = 0; byte_no = 0; sr = 0; last_rise = -1; nack_pend = 0;
      end else if (prev_scl && scl_ln && !prev_sda && sda_ln) begin
        chk(in_frame && byte_no == 2, "R3 one data byte then STOP", byte_no, 2);
        stops++; last_stop = cyc; in_frame = 0;
      end
      if (in_frame && !prev_scl && scl_ln) begin
        if (last_rise >= 0) chk(cyc - last_rise == DIV, "R4 SCL period", cyc - last_rise, DIV);
        last_rise = cyc;
        if (bitcnt < 8) begin
          sr = ((sr << 1) | int'(sda_ln)) & 'hFF;
          bitcnt++;
        end
      end
      if (in_frame && prev_scl && !scl_ln) begin
        if (bitcnt == 8) begin
          e = (byte_no == 0) ? (exp_addr(t) << 1) : exp_data(t);
          chk(sr == e, (byte_no == 0) ? "R1 address byte" : "R1 data byte", sr, e);
          nak = (byte_no == 0 && t == 1 && !nak_a) || (byte_no == 1 && t == 2 && !nak_d);
          if (nak) begin
            if (byte_no == 0) nak_a = 1; else nak_d = 1;
            nack_exp++; nack_pend = 1; tb_sda_lo = 1'b0;
          end else begin
            tb_sda_lo = 1'b1;
          end
          bitcnt = 9;
        end else if (bitcnt == 9) begin
          tb_sda_lo = 1'b0;
          bitcnt = 0;
          byte_no++;
        end
      end
    end
    prev_scl = scl_ln;
    prev_sda = sda_ln;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R8 reset state
    chk(!scl_oe && !sda_oe, "R8 lines released in reset", {scl_oe, sda_oe}, 0);
    chk(!busy && !done && !nack, "R8 status low in reset", {busy, done, nack}, 0);
    chk(idx == 0, "R8 idx zero in reset", idx, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(!busy && scl_ln && sda_ln, "R6 initial gap idle", {busy, scl_ln, sda_ln}, 3);
    for (int i = 0; i < 100000 && t < NTX; i++) @(negedge clk);
    if (t < NTX) begin
      total++; bad++;
      $display("FAIL R7 watchdog act=%0d exp=%0d", t, NTX);
    end
    chk(nack_seen == 2, "R5 total nack pulses", nack_seen, 2);
    chk(nak_a && nak_d, "R5 both NACK cases reached", {nak_a, nak_d}, 3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule